// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Write-Path Slave

This block is the device-side logic of a three-wire serial EEPROM, reduced to its write path. A host drives a chip select, a serial clock and a serial data line. While chip select is high, the block samples the data line on each rising serial-clock edge. It waits for a start bit, then collects a two-bit opcode, an address and a data word. The frame is acted on when chip select falls. A single-location write or a whole-array write then runs a self-timed programming cycle of a fixed number of system clocks. That cycle first erases its target and then programs it.

The status output is modelled as a data bit plus an output enable. If chip select comes back high after staying low long enough, the output reports busy (0) while programming runs and ready (1) once it has finished. Writes take effect only after an enable instruction has been received. The array is a small register file with a parallel read port, which the surrounding logic uses to look at the stored words. The data word is 8 bits by default, or 16 bits when the organisation parameter `ORG16` is set.

Top module: `ee3w_write_slave`

## Requirements
- R1: Zeros clocked in before the first 1 are ignored. The first 1 is the start bit. After it come a 2-bit opcode, an ADDR_W-bit address and, for writes, a WORD_W-bit data word, all MSB first and sampled on rising `sclk_i` while `cs_i` is high.
- R2: The opcode 01 followed by a complete data word launches a programming cycle of PROG_CYC clocks when `cs_i` falls. At the end of that cycle the addressed word holds the data and every other word is unchanged.
- R3: While a programming cycle runs, its target already reads all ones: the addressed word for a single write, and every word for a write-all.
- R4: Opcode 00 with address bits [ADDR_W-1:ADDR_W-2] = 01 and a complete data word is a write-all. When it ends, every word holds the data, and no serial-clock edges are needed during the cycle.
- R5: Opcode 00 with top address bits 11 enables writing, and with top address bits 00 it disables writing. The block leaves reset write-disabled. While disabled, write and write-all change nothing and start no cycle.
- R6: Suppose a programming cycle has been launched since the last accepted start bit. If `cs_i` is then raised after being low for at least MIN_GAP clocks, `do_oe_o` goes to 1 and `do_o` shows 0 while busy and 1 once the cycle is done.
- R7: `do_oe_o` is 0 after reset and while `cs_i` is low. It is also 0 after a rise of `cs_i` that follows a low gap shorter than MIN_GAP or that comes with no launched cycle. The status window closes at the next start bit.
- R8: If `cs_i` falls before a write's data word is complete, no cycle starts and the array is unchanged.
- R9: Every instruction completed while a cycle runs is ignored, including enable and disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Serial chip select, active high |
| sclk_i | input | 1 | Serial clock, sampled by `clk_i` |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Status bit: 0 busy, 1 ready |
| do_oe_o | output | 1 | Output enable for `do_o`; 0 means high impedance |
| rd_addr_i | input | ADDR_W | Parallel read address into the array |
| rd_data_o | output | WORD_W | Array word at `rd_addr_i` |

## Verification
A mis-decoded frame or a lost enable state shows up on the array read port within a few clocks of the chip-select fall, as a target word that is not erased to all ones. A wrong cycle counter shows up PROG_CYC clocks later, as a word holding the wrong value or as a status bit still reporting busy. A wrong gap counter or a stale status-window flag shows up within two clocks of a chip-select rise, through the output enable, so the bench probes the status at short and long gaps and after a start bit.

// File: rtl/ee3w_pkg.sv
// Shared types for the three-wire EEPROM write-path slave.
package ee3w_pkg;
    // Instruction decoded from one chip-select frame.
    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_WRALL = 3'd2,
        CMD_WEN   = 3'd3,
        CMD_WDIS  = 3'd4
    } ee3w_cmd_e;
endpackage

// File: rtl/ee3w_rx.sv
// Serial receiver: finds the start bit and shifts in the header and the data
// word. It classifies the frame when chip select falls.
// Assumes: inputs are already registered into clk domain; ADDR_W >= 2.
module ee3w_rx #(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  cs_q,
    input  logic                  cs_prev,
    input  logic                  sclk_rise,
    input  logic                  di_q,
    output logic                  start_o,
    output logic                  cmd_valid_o,
    output ee3w_pkg::ee3w_cmd_e   cmd_kind_o,
    output logic [ADDR_W-1:0]     cmd_addr_o,
    output logic [WORD_W-1:0]     cmd_data_o
);
    import ee3w_pkg::*;

    localparam int HDR_W   = 2 + ADDR_W;
    localparam int FRAME_W = HDR_W + WORD_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic                started;
    logic [CNT_W-1:0]    cnt;
    logic [HDR_W-1:0]    hdr;
    logic [WORD_W-1:0]   dat;
    ee3w_cmd_e           kind;
    logic [1:0]          op;
    logic [1:0]          top2;

    // Classify the frame from the collected bits and the bit count.
    always_comb begin
        op   = hdr[HDR_W-1 -: 2];
        top2 = hdr[ADDR_W-1 -: 2];
        kind = CMD_NONE;
        if (op == 2'b01 && cnt == CNT_W'(FRAME_W)) begin
            kind = CMD_WRITE;
        end else if (op == 2'b00) begin
            if (top2 == 2'b01 && cnt == CNT_W'(FRAME_W))     kind = CMD_WRALL;
            else if (top2 == 2'b11 && cnt >= CNT_W'(HDR_W))  kind = CMD_WEN;
            else if (top2 == 2'b00 && cnt >= CNT_W'(HDR_W))  kind = CMD_WDIS;
        end
    end

    // Shift bits on serial-clock rises and emit a command on chip-select fall.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            started     <= 1'b0;
            cnt         <= '0;
            hdr         <= '0;
            dat         <= '0;
            start_o     <= 1'b0;
            cmd_valid_o <= 1'b0;
            cmd_kind_o  <= CMD_NONE;
            cmd_addr_o  <= '0;
            cmd_data_o  <= '0;
        end else begin
            start_o     <= 1'b0;
            cmd_valid_o <= 1'b0;
            if (cs_prev && !cs_q) begin
                cmd_valid_o <= started;
                cmd_kind_o  <= started ? kind : CMD_NONE;
                cmd_addr_o  <= hdr[ADDR_W-1:0];
                cmd_data_o  <= dat;
                started     <= 1'b0;
                cnt         <= '0;
            end else if (!cs_q) begin
                started <= 1'b0;
                cnt     <= '0;
            end else if (sclk_rise) begin
                if (!started) begin
                    if (di_q) begin
                        started <= 1'b1;
                        start_o <= 1'b1;
                    end
                end else if (cnt < CNT_W'(FRAME_W)) begin
                    if (cnt < CNT_W'(HDR_W)) hdr <= {hdr[HDR_W-2:0], di_q};
                    else                     dat <= {dat[WORD_W-2:0], di_q};
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ee3w_timer.sv
// Programming-cycle counter and ready/busy status window.
// Assumes: launch_i never arrives while busy_o is high.
module ee3w_timer #(
    parameter int PROG_CYC = 200,
    parameter int MIN_GAP  = 50
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_q,
    input  logic cs_prev,
    input  logic launch_i,
    input  logic start_i,
    output logic busy_o,
    output logic commit_o,
    output logic do_oe_o,
    output logic do_o
);
    localparam int PC_W  = $clog2(PROG_CYC + 1);
    localparam int GAP_W = $clog2(MIN_GAP + 1);

    logic [PC_W-1:0]  left;
    logic [GAP_W-1:0] gap;
    logic             armed;
    logic             win;

    assign busy_o   = (left != '0);
    assign commit_o = (left == PC_W'(1));
    assign do_oe_o  = win;
    assign do_o     = !busy_o;

    // Count down the self-timed programming cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)            left <= '0;
        else if (launch_i)      left <= PC_W'(PROG_CYC);
        else if (left != '0)    left <= left - 1'b1;
    end

    // Measure how long chip select has stayed low, saturating.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                           gap <= '0;
        else if (cs_q)                         gap <= '0;
        else if (gap < GAP_W'(MIN_GAP))        gap <= gap + 1'b1;
    end

    // Remember a launch until a new instruction starts while idle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                    armed <= 1'b0;
        else if (launch_i)              armed <= 1'b1;
        else if (start_i && !busy_o)    armed <= 1'b0;
    end

    // Open the status window on a qualified chip-select rise.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                 win <= 1'b0;
        else if (!cs_q)              win <= 1'b0;
        else if (!cs_prev)           win <= armed && (gap >= GAP_W'(MIN_GAP));
        else if (start_i)            win <= 1'b0;
    end
endmodule

// File: rtl/ee3w_array.sv
// Register-file array with per-word and whole-array erase (to all ones) and
// program, plus a combinational read port.
// Assumes: erase and program requests are never raised in the same cycle.
module ee3w_array #(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              erase_one_i,
    input  logic              erase_all_i,
    input  logic              prog_one_i,
    input  logic              prog_all_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        // Erase or program one word of the array.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                mem[i] <= '1;
            else if (erase_all_i || (erase_one_i && addr_i == ADDR_W'(i)))
                mem[i] <= '1;
            else if (prog_all_i || (prog_one_i && addr_i == ADDR_W'(i)))
                mem[i] <= data_i;
        end
    end

    assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/ee3w_write_slave.sv
// Top of the three-wire EEPROM write path. It registers the serial pins,
// holds the write-enable state, launches programming cycles and connects the array.
// Assumes: serial pins change slowly compared with clk_i (several clocks per
// serial-clock phase).
module ee3w_write_slave #(
    parameter int ADDR_W   = 4,
    parameter bit ORG16    = 1'b0,
    parameter int PROG_CYC = 200,
    parameter int MIN_GAP  = 50,
    localparam int WORD_W  = ORG16 ? 16 : 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_i,
    input  logic              sclk_i,
    input  logic              di_i,
    output logic              do_o,
    output logic              do_oe_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o
);
    import ee3w_pkg::*;

    logic              cs_q, cs_prev, sclk_q, sclk_prev, di_q;
    logic              start, cmd_valid, busy, commit, wen, pend_all;
    ee3w_cmd_e         cmd_kind;
    logic [ADDR_W-1:0] cmd_addr, pend_addr, arr_addr;
    logic [WORD_W-1:0] cmd_data, pend_data;
    logic              accept, launch_one, launch_all, launch;

    // Register the serial pins and keep one cycle of history for edges.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cs_q <= 1'b0; cs_prev <= 1'b0;
            sclk_q <= 1'b0; sclk_prev <= 1'b0; di_q <= 1'b0;
        end else begin
            cs_q <= cs_i; cs_prev <= cs_q;
            sclk_q <= sclk_i; sclk_prev <= sclk_q; di_q <= di_i;
        end
    end

    ee3w_rx #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rx (
        .clk_i(clk_i), .rst_ni(rst_ni), .cs_q(cs_q), .cs_prev(cs_prev),
        .sclk_rise(sclk_q && !sclk_prev), .di_q(di_q), .start_o(start),
        .cmd_valid_o(cmd_valid), .cmd_kind_o(cmd_kind),
        .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
    );

    assign accept     = cmd_valid && !busy;
    assign launch_one = accept && wen && (cmd_kind == CMD_WRITE);
    assign launch_all = accept && wen && (cmd_kind == CMD_WRALL);
    assign launch     = launch_one || launch_all;
    assign arr_addr   = launch_one ? cmd_addr : pend_addr;

    // Track write enable and hold the pending operation for the commit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wen <= 1'b0; pend_all <= 1'b0;
            pend_addr <= '0; pend_data <= '0;
        end else begin
            if (accept && cmd_kind == CMD_WEN)  wen <= 1'b1;
            if (accept && cmd_kind == CMD_WDIS) wen <= 1'b0;
            if (launch) begin
                pend_all  <= launch_all;
                pend_addr <= cmd_addr;
                pend_data <= cmd_data;
            end
        end
    end

    ee3w_timer #(.PROG_CYC(PROG_CYC), .MIN_GAP(MIN_GAP)) u_timer (
        .clk_i(clk_i), .rst_ni(rst_ni), .cs_q(cs_q), .cs_prev(cs_prev),
        .launch_i(launch), .start_i(start), .busy_o(busy), .commit_o(commit),
        .do_oe_o(do_oe_o), .do_o(do_o)
    );

    ee3w_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .erase_one_i(launch_one), .erase_all_i(launch_all),
        .prog_one_i(commit && !pend_all), .prog_all_i(commit && pend_all),
        .addr_i(arr_addr), .data_i(pend_data),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );
endmodule

// File: rtl/ee3w_write_slave_chk.sv
// Property checker for ee3w_write_slave, attached through bind below.
module ee3w_write_slave_chk #(
    parameter int PROG_CYC = 200
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                cs_q,
    input logic                cs_prev,
    input logic                busy,
    input logic                wen,
    input logic                cmd_valid,
    input ee3w_pkg::ee3w_cmd_e cmd_kind,
    input logic                do_oe_o
);
    import ee3w_pkg::*;

    int busy_len;

    // Count consecutive busy cycles to check the programming length.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)   busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    a_r7_hiz_cs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_q && !cs_prev) |-> !do_oe_o);

    a_r2_prog_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy && $past(busy)) |-> (busy_len == PROG_CYC));

    a_r5_launch_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy) |-> $past(wen));

    a_r9_busy_keeps_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && cmd_valid) |=> (wen == $past(wen)));

    a_r8_abort_no_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid && cmd_kind == CMD_NONE) |=> !$rose(busy));
endmodule

bind ee3w_write_slave ee3w_write_slave_chk #(.PROG_CYC(PROG_CYC)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_q(cs_q), .cs_prev(cs_prev),
    .busy(busy), .wen(wen), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .do_oe_o(do_oe_o)
);

// File: tb/ee3w_write_slave_bench.sv
// Scoreboard bench: the driver queues expected array words, the monitor pops
// them and compares against the read port.
module ee3w_write_slave_bench;
    localparam int ADDR_W = 4;
    localparam int WORD_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PROG   = 200;
    localparam int GAP    = 50;

    typedef struct {
        int    addr;
        int    data;
        string tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
    logic do_bit, do_oe;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [WORD_W-1:0] rd_data;

    int   checks = 0, fails = 0;
    exp_t exp_q[$];
    bit   mon_busy = 1'b0;
    int   shadow [DEPTH];

    always #2.5 clk = ~clk;

    ee3w_write_slave #(.ADDR_W(ADDR_W), .ORG16(1'b0), .PROG_CYC(PROG), .MIN_GAP(GAP))
    u_ee3w_write_slave (
        .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
        .do_o(do_bit), .do_oe_o(do_oe), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop expected words and compare against the read port.
    initial begin
        exp_t it;
        forever begin
            wait (exp_q.size() != 0);
            mon_busy = 1'b1;
            it = exp_q.pop_front();
            @(negedge clk) rd_addr = ADDR_W'(it.addr);
            @(negedge clk);
            chk(it.tag, int'(rd_data), it.data);
            mon_busy = 1'b0;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_all(input string tag);
        for (int a = 0; a < DEPTH; a++) exp_q.push_back('{a, shadow[a], tag});
        wait (exp_q.size() == 0 && !mon_busy);
    endtask

    task automatic expect_one(input int a, input int d, input string tag);
        exp_q.push_back('{a, d, tag});
        wait (exp_q.size() == 0 && !mon_busy);
    endtask

    task automatic tick_bit(input logic b);
        @(negedge clk) di = b;
        wait_clk(3); sclk = 1'b1;
        wait_clk(3); sclk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n, input int lead);
        @(negedge clk) cs = 1'b1;
        wait_clk(3);
        for (int i = 0; i < lead; i++) tick_bit(1'b0);
        for (int i = n - 1; i >= 0; i--) tick_bit(v[i]);
        wait_clk(3);
        cs = 1'b0;
    endtask

    task automatic wr(input int a, input int d, input int lead);
        send({17'd0, 1'b1, 2'b01, 4'(a), 8'(d)}, 15, lead);
    endtask
    task automatic wrall(input int d);
        send({17'd0, 1'b1, 2'b00, 4'b0100, 8'(d)}, 15, 0);
    endtask
    task automatic wen_cmd();  send(32'b1001100, 7, 0); endtask
    task automatic wdis_cmd(); send(32'b1000000, 7, 0); endtask

    // Raise CS after a low gap and sample the status pins; CS stays high.
    task automatic raise_after(input int g, output logic oe, output logic bv);
        @(negedge clk) cs = 1'b0;
        wait_clk(g);
        cs = 1'b1;
        wait_clk(4);
        oe = do_oe; bv = do_bit;
    endtask

    initial begin
        logic oe, bv;
        for (int a = 0; a < DEPTH; a++) shadow[a] = 'hFF;
        wait_clk(4);
        chk("R7 reset oe", int'(do_oe), 0);
        rst_n = 1'b1;
        wait_clk(2);
        expect_all("R5 reset erased");

        // R5: write while disabled does nothing
        wr(3, 'hA5, 0); wait_clk(20);
        chk("R5 disabled cs low oe", int'(do_oe), 0);
        raise_after(60, oe, bv); cs = 1'b0;
        chk("R7 no launch oe", int'(oe), 0);
        wait_clk(250);
        expect_all("R5 disabled write");

        // R1/R2/R3/R6: enabled write with leading zeros
        wen_cmd(); wait_clk(10);
        wr(3, 'h5A, 2); wait_clk(20);
        expect_one(3, 'hFF, "R3 erase before program");
        raise_after(60, oe, bv); cs = 1'b0;
        chk("R6 busy oe", int'(oe), 1);
        chk("R6 busy bit", int'(bv), 0);
        wait_clk(250);
        shadow[3] = 'h5A;
        expect_all("R2 R1 write result");
        raise_after(60, oe, bv); cs = 1'b0;
        chk("R6 ready oe", int'(oe), 1);
        chk("R6 ready bit", int'(bv), 1);

        // R7: short gap gives no status
        wr(4, 'h44, 0);
        raise_after(10, oe, bv); cs = 1'b0;
        chk("R7 short gap oe", int'(oe), 0);
        wait_clk(250);
        shadow[4] = 'h44;
        expect_one(4, 'h44, "R2 second write");

        // R9: disable during busy is ignored
        wr(5, 'h11, 0); wait_clk(60);
        wdis_cmd(); wait_clk(250);
        wr(7, 'h77, 0); wait_clk(250);
        shadow[5] = 'h11; shadow[7] = 'h77;
        expect_all("R9 busy ignore");

        // R8: aborted frame
        send({17'd0, 1'b1, 2'b01, 4'd8, 8'h88} >> 5, 10, 0);
        wait_clk(250);
        expect_all("R8 abort array");
        raise_after(60, oe, bv); cs = 1'b0;
        chk("R8 abort no status", int'(oe), 0);

        // R3/R4: write-all, no serial clock during the cycle
        wrall('hC3); wait_clk(20);
        for (int a = 0; a < DEPTH; a++) shadow[a] = 'hFF;
        expect_all("R3 write-all erase");
        wait_clk(250);
        for (int a = 0; a < DEPTH; a++) shadow[a] = 'hC3;
        expect_all("R4 write-all result");
        raise_after(60, oe, bv);
        chk("R6 wrall ready oe", int'(oe), 1);
        chk("R6 wrall ready bit", int'(bv), 1);
        tick_bit(1'b1); wait_clk(4);
        chk("R7 start closes window", int'(do_oe), 0);
        cs = 1'b0; wait_clk(10);

        // R5: disable then writes ignored
        wdis_cmd(); wait_clk(10);
        wr(2, 'h00, 0); wait_clk(250);
        wrall('h0F); wait_clk(250);
        expect_all("R5 disabled after disable");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule